// File: doc/BRIEF.md
# Fixed-Operand Accumulator Processor Core

This block is a 32-bit processor in which each instruction is read, decoded, executed and retired in one clock. Its state is small: an 8-bit program counter, a 256-word instruction store and three 32-bit registers. Two of these registers are fixed operand sources. The third is an accumulator, and it is the only destination. An instruction names only an operation, which is held in its top three bits. It names no register and carries no immediate value. The operations are addition, subtraction and bitwise AND. Arithmetic wraps modulo 2^32, and the core raises no flags. The program counter steps through the store in order and wraps back to zero. There are no branches or jumps.

A run input gates the machine. While run is high, the core executes one instruction on every edge. While run is low, the core is idle and a synchronous load port can write any instruction word or either operand register. This lets a test environment preload a program and its operands. It can then release the core and follow the accumulator output, instruction by instruction.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, both operand registers and the accumulator to zero. The instruction store is not cleared.
- R2: While run is high, an instruction whose bits [31:29] equal 3'b001 writes the first operand plus the second operand, modulo 2^32, to the accumulator at the same edge that retires it.
- R3: While run is high, opcode 3'b010 writes the first operand minus the second operand, modulo 2^32, to the accumulator.
- R4: While run is high, opcode 3'b011 writes the bitwise AND of the two operands to the accumulator.
- R5: Opcode 3'b000 and the unused codes 3'b100 to 3'b111 leave the accumulator unchanged.
- R6: While run is high, the program counter advances by one on every edge and wraps from 255 to 0. The instruction executed is always the store word at the current program counter.
- R7: While run is low, the program counter and the accumulator hold their values. Each active load strobe writes its target (one store word at the given address, the first operand or the second operand) on that edge.
- R8: Load strobes asserted while run is high have no effect on the operand registers or on the instruction store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High: execute one instruction per edge. Low: idle and accept loads |
| ld_imem_we | input | 1 | Write strobe for the instruction store |
| ld_imem_addr | input | 8 | Store address for the load |
| ld_imem_data | input | 32 | Instruction word to load |
| ld_opa_we | input | 1 | Write strobe for the first operand register |
| ld_opb_we | input | 1 | Write strobe for the second operand register |
| ld_reg_data | input | 32 | Value loaded into the selected operand register(s) |
| pc_o | output | 8 | Current program counter |
| acc_o | output | 32 | Accumulator value |

## Verification
Two functions can be requested in the same cycle: execution, and a load through the test port. The bench provokes this by holding every load strobe active during a stretch of execution. Its data differs from the current operands, and its store address is set to a word the program will reach shortly. The reference model ignores such loads, and it compares the accumulator on every edge. A load that slipped through would therefore show up in that cycle's results, and again when the targeted store word is executed later. The wrap of the program counter and the wrap of the arithmetic are judged in the same run.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    parameter int unsigned WORD_W = 32;
    parameter int unsigned PC_W   = 8;
    parameter int unsigned OPC_W  = 3;

    // opcode field values (top bits of an instruction word)
    typedef enum logic [OPC_W-1:0] {
        OPC_IDLE = 3'b000,
        OPC_SUM  = 3'b001,
        OPC_DIFF = 3'b010,
        OPC_MASK = 3'b011
    } opc_e;

    // internal ALU selector
    typedef enum logic [2:0] {
        ALU_AND  = 3'b000,
        ALU_ADD  = 3'b010,
        ALU_SUB  = 3'b110,
        ALU_NONE = 3'b111
    } alu_sel_e;

    typedef struct packed {
        alu_sel_e sel;
        logic     acc_we;
    } ctrl_t;

    function automatic ctrl_t decode_opcode(input logic [OPC_W-1:0] opc);
        ctrl_t c;
        c.sel    = ALU_NONE;
        c.acc_we = 1'b0;
        case (opc)
            OPC_SUM:  begin c.sel = ALU_ADD; c.acc_we = 1'b1; end
            OPC_DIFF: begin c.sel = ALU_SUB; c.acc_we = 1'b1; end
            OPC_MASK: begin c.sel = ALU_AND; c.acc_we = 1'b1; end
            default:  begin c.sel = ALU_NONE; c.acc_we = 1'b0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_imem.sv
module acc_imem #(
    parameter int unsigned ADDR_W = acc_core_pkg::PC_W,
    parameter int unsigned DATA_W = acc_core_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // combinational read: fetch completes within the executing cycle
    assign rdata = mem[raddr];
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  logic [DATA_W-1:0] instr,
    output ctrl_t             ctrl
);
    localparam int unsigned OPC_LSB = DATA_W - OPC_W;

    always_comb begin
        ctrl = decode_opcode(instr[DATA_W-1:OPC_LSB]);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W
) (
    input  alu_sel_e          sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (sel)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned ADDR_W = PC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              ld_imem_we,
    input  logic [ADDR_W-1:0] ld_imem_addr,
    input  logic [DATA_W-1:0] ld_imem_data,
    input  logic              ld_opa_we,
    input  logic              ld_opb_we,
    input  logic [DATA_W-1:0] ld_reg_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] opa_q, opb_q, acc_q;
    logic [DATA_W-1:0] instr;
    logic [DATA_W-1:0] alu_y;
    ctrl_t             ctrl;

    acc_imem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_imem (
        .clk   (clk),
        .we    (ld_imem_we & ~run),
        .waddr (ld_imem_addr),
        .wdata (ld_imem_data),
        .raddr (pc_q),
        .rdata (instr)
    );

    acc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .instr (instr),
        .ctrl  (ctrl)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .sel (ctrl.sel),
        .a   (opa_q),
        .b   (opb_q),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            acc_q <= '0;
        end else if (run) begin
            pc_q <= pc_q + ADDR_W'(1);
            if (ctrl.acc_we) acc_q <= alu_y;
        end else begin
            if (ld_opa_we) opa_q <= ld_reg_data;
            if (ld_opb_we) opb_q <= ld_reg_data;
        end
    end

    assign pc_o  = pc_q;
    assign acc_o = acc_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int unsigned DATA_W = acc_core_pkg::WORD_W,
    parameter int unsigned ADDR_W = acc_core_pkg::PC_W
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input logic [DATA_W-1:0] instr,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb
);
    localparam int unsigned OPC_LSB = DATA_W - 3;
    logic [2:0] opc;
    assign opc = instr[DATA_W-1:OPC_LSB];

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        run |=> pc == $past(pc) + ADDR_W'(1)); // R6
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(pc)); // R7
    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(acc)); // R7
    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (run && opc == 3'b001) |=> acc == $past(opa) + $past(opb)); // R2
    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
        (run && opc == 3'b010) |=> acc == $past(opa) - $past(opb)); // R3
    AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
        (run && opc == 3'b011) |=> acc == ($past(opa) & $past(opb))); // R4
    AST_NOP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (run && (opc == 3'b000 || opc[2])) |=> $stable(acc)); // R5
    AST_RUN_LOCKS_OPERANDS: assert property (@(posedge clk) disable iff (rst)
        run |=> ($stable(opa) && $stable(opb))); // R8
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .pc    (pc_q),
    .acc   (acc_q),
    .instr (instr),
    .opa   (opa_q),
    .opb   (opb_q)
);

// File: tb/acc_core_test.sv
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        ld_imem_we = 1'b0;
    logic [7:0]  ld_imem_addr = '0;
    logic [31:0] ld_imem_data = '0;
    logic        ld_opa_we = 1'b0;
    logic        ld_opb_we = 1'b0;
    logic [31:0] ld_reg_data = '0;
    logic [7:0]  pc_o;
    logic [31:0] acc_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // behavioural reference state
    logic [31:0] m_mem [256];
    logic [31:0] m_a, m_b, m_acc;
    int          m_pc;

    always #5 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst(rst), .run(run),
        .ld_imem_we(ld_imem_we), .ld_imem_addr(ld_imem_addr), .ld_imem_data(ld_imem_data),
        .ld_opa_we(ld_opa_we), .ld_opb_we(ld_opb_we), .ld_reg_data(ld_reg_data),
        .pc_o(pc_o), .acc_o(acc_o)
    );

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // one clock: update the model from the driven inputs, then compare after the edge
    task automatic tick(input string force_tag);
        string pc_tag, acc_tag;
        logic [2:0] op;
        @(posedge clk);
        if (rst) begin
            m_pc = 0; m_a = 0; m_b = 0; m_acc = 0;
            pc_tag = "R1"; acc_tag = "R1";
        end else if (run) begin
            op = m_mem[m_pc][31:29];
            pc_tag = "R6";
            case (op)
                3'b001: begin m_acc = m_a + m_b; acc_tag = "R2"; end
                3'b010: begin m_acc = m_a - m_b; acc_tag = "R3"; end
                3'b011: begin m_acc = m_a & m_b; acc_tag = "R4"; end
                default: acc_tag = "R5";
            endcase
            m_pc = (m_pc + 1) % 256;
        end else begin
            if (ld_imem_we) m_mem[ld_imem_addr] = ld_imem_data;
            if (ld_opa_we) m_a = ld_reg_data;
            if (ld_opb_we) m_b = ld_reg_data;
            pc_tag = "R7"; acc_tag = "R7";
        end
        if (force_tag != "") begin
            pc_tag = force_tag; acc_tag = force_tag;
        end
        #1;
        check(pc_tag, "pc", {24'h0, pc_o}, 32'(m_pc));
        check(acc_tag, "acc", acc_o, m_acc);
    endtask

    function automatic logic [31:0] prog_word(input int i);
        logic [2:0] code;
        case (i % 6)
            0: code = 3'b001;
            1: code = 3'b010;
            2: code = 3'b011;
            3: code = 3'b000;
            4: code = 3'b001;
            default: code = 3'(4 + (i / 6) % 4);
        endcase
        return {code, 29'(i * 32'h9E37_79B1)};
    endfunction

    task automatic load_ops(input logic [31:0] a, input logic [31:0] b);
        run = 0;
        ld_opa_we = 1; ld_reg_data = a; tick("R7");
        ld_opa_we = 0; ld_opb_we = 1; ld_reg_data = b; tick("R7");
        ld_opb_we = 0;
    endtask

    task automatic run_n(input int n, input string tag);
        run = 1;
        for (int k = 0; k < n; k++) tick(tag);
        run = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        m_pc = 0; m_a = 0; m_b = 0; m_acc = 0;
        // R1: reset state
        tick("R1");
        tick("R1");
        rst = 0;

        // R7: fill the instruction store while idle
        for (int i = 0; i < 256; i++) begin
            ld_imem_we = 1; ld_imem_addr = 8'(i); ld_imem_data = prog_word(i);
            tick("");
        end
        ld_imem_we = 0;

        // R1: operands loaded, then reset must clear them (word 0 is an add)
        load_ops(32'd5, 32'd7);
        rst = 1; tick("R1"); rst = 0;
        run_n(1, "R1");

        // R2/R3/R4/R5 with an add that wraps
        load_ops(32'hFFFF_FFF0, 32'h0000_0025);
        run_n(6, "");

        // R7: idle cycles, with a store rewrite at a later address
        tick("");
        ld_imem_we = 1; ld_imem_addr = 8'd9; ld_imem_data = {3'b010, 29'h0};
        tick("");
        ld_imem_we = 0;
        tick("");

        // R8: loads presented during execution are ignored
        ld_opa_we = 1; ld_opb_we = 1; ld_reg_data = 32'hDEAD_BEEF;
        ld_imem_we = 1; ld_imem_addr = 8'd12; ld_imem_data = {3'b011, 29'h0};
        run_n(4, "R8");
        ld_opa_we = 0; ld_opb_we = 0; ld_imem_we = 0;
        run_n(6, "");

        // R3 negative wrap, then run past 255 for the counter wrap (R6)
        load_ops(32'd3, 32'd10);
        run_n(260, "");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule